// File: doc/BRIEF.md
# Multimode Capture/Compare Timer

A general-purpose timer around one free-running 16-bit up-counter. The counter advances in one of three ways:

- **Timer mode:** it is fed through an 8-bit prescaler. The prescaler input is either every system clock cycle or each rising edge of the timer input pin.
- **Capture mode:** it runs as in timer mode, and a chosen edge of the input pin copies the live count into a capture register.
- **Event mode:** each chosen edge of the input pin adds one to the count directly, without the prescaler.

A programmable reference value is compared with the counter. On a match the block raises a sticky status flag and can restart the count from zero. The match also drives the timer output pin, either as a one-clock active-low pulse or as a toggle.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no valid/ready handshake and no back-pressure, because every access completes in one cycle.

The input pin passes through a two-flop synchronizer before any edge is detected. Capture and reference events set status bits that software clears by writing ones. The interrupt line is the OR of the status bits whose enables are set.

Register map, by `reg_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | Control | read/write |
| 1 | Prescale (8 bits) | read/write |
| 2 | Reference | read/write |
| 3 | Capture | read-only |
| 4 | Counter | read/write |
| 5 | Status | read, write-1-to-clear |

Control register bits:

| Bits | Field |
|---|---|
| 0 | run |
| 2:1 | mode: 00 timer, 01 capture, 10 event, 11 same as timer |
| 3 | count source: 0 = system clock, 1 = input-pin rising edges |
| 5:4 | edge select |
| 6 | restart on match |
| 7 | output toggle mode (0 = pulse) |
| 8 | reference interrupt enable |
| 9 | capture interrupt enable |

Status register bits: bit 0 is the capture flag and bit 1 is the reference flag.

Top module: `mmtimer`

## Requirements
- R1: After reset the counter, capture and status read 0, `tmr_out` is 1 and `irq` is 0.
- R2: With the system-clock source and prescale value P, the counter advances once every P+1 clock edges. The count is measured from the write to the counter register, and that write reloads the counter and clears the prescaler.
- R3: While run (control bit 0) is 0, the counter holds its value.
- R4: Without restart, the counter counts through 0xFFFF and wraps to 0x0000.
- R5: With restart (control bit 6), the increment that follows a count equal to the reference loads 0, so the count period is reference+1 steps.
- R6: An increment that brings the counter to the reference value sets status bit 1 in the same cycle. `irq` is high while status bit 1 is set and control bit 8 is 1.
- R7: In pulse mode (control bit 7 = 0), `tmr_out` is 0 for exactly the one clock after a match and 1 otherwise.
- R8: In toggle mode (control bit 7 = 1), `tmr_out` inverts on each match and holds otherwise.
- R9: In capture mode (mode 01) with run set, a selected input edge copies the current count into the capture register and sets status bit 0.
- R10: Edge select (control bits 5:4) is 01 rising, 10 falling, 11 both, 00 none. An edge that is not selected has no effect on the capture register or the counter.
- R11: In event mode (mode 10), the counter advances by one on each selected input edge and the prescaler is bypassed.
- R12: With the pin source (control bit 3 = 1), rising edges of the synchronized pin feed the prescaler in place of the system clock.
- R13: Writing 1 to a status bit clears it. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| tmr_in | input | 1 | Timer input pin (asynchronous) |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are a software clear of the reference flag and a fresh reference match. Setting the reference to 0 with restart enabled and a prescale of 0 makes every clock edge a match. A write-1-to-clear issued while the counter runs therefore always collides with a set, and the bench expects status bit 1 to read back as 1. The bench then stops the counter and clears again, and expects the bit to read 0. This proves the clear path works and that the set wins only when the two coincide.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'b00,
    MODE_CAPTURE = 2'b01,
    MODE_EVENT   = 2'b10,
    MODE_ALT     = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic      cap_ie;
    logic      ref_ie;
    logic      toggle;
    logic      restart;
    logic [1:0] edge_sel;
    logic      ext_src;
    tmr_mode_e mode;
    logic      run;
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_PRE   = 3'd1;
  localparam logic [2:0] A_REF   = 3'd2;
  localparam logic [2:0] A_CAP   = 3'd3;
  localparam logic [2:0] A_COUNT = 3'd4;
  localparam logic [2:0] A_STAT  = 3'd5;
endpackage

// File: rtl/tmr_pin_sync.sv
`timescale 1ns/1ps
module tmr_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       rise_o,
  output logic       sel_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;
  logic              fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~prev_q;
  assign fall   = ~level & prev_q;

  always_comb begin
    unique case (edge_sel_i)
      2'b01:   sel_o = rise_o;
      2'b10:   sel_o = fall;
      2'b11:   sel_o = rise_o | fall;
      default: sel_o = 1'b0;
    endcase
  end

  AST_NO_BACK_TO_BACK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R10
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             src_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  localparam logic [PRE_W-1:0] ONE = 1;
  logic [PRE_W-1:0] pre_q;

  assign tick_o = src_i && !clr_i && (pre_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (clr_i)    pre_q <= '0;
    else if (tick_o)   pre_q <= '0;
    else if (src_i)    pre_q <= pre_q + ONE;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || div_i == '0)); // R2
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] ref_i,
  input  logic             restart_i,
  input  logic             toggle_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             match_o,
  output logic             tout_o
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [CNT_W-1:0] cnt_q, cap_q, nxt;
  logic             tout_q;

  always_comb begin
    nxt     = (restart_i && cnt_q == ref_i) ? '0 : cnt_q + ONE;
    match_o = inc_i && !load_i && (nxt == ref_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cap_q <= '0;
    else if (cap_i) cap_q <= cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tout_q <= 1'b1;
    else if (toggle_i) tout_q <= match_o ? ~tout_q : tout_q;
    else               tout_q <= ~match_o;
  end

  assign cnt_o  = cnt_q;
  assign cap_o  = cap_q;
  assign tout_o = tout_q;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(cnt_q)); // R3
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i && restart_i && cnt_q == ref_i) |=> (cnt_q == '0)); // R5
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (cap_q == $past(cnt_q))); // R9
  AST_TOGGLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle_i && !match_o) |=> $stable(tout_q)); // R8
endmodule

// File: rtl/mmtimer.sv
`timescale 1ns/1ps
module mmtimer #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             tmr_in,
  output logic             tmr_out,
  output logic             irq
);
  import tmr_pkg::*;

  tmr_ctrl_t        ctrl_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] ref_q;
  logic             st_cap_q, st_ref_q;
  logic             pin_rise, pin_sel, src_pulse, tick, inc, load, cap_ev, match;
  logic             wr_stat, clr_cap, clr_ref;
  logic [CNT_W-1:0] cnt, cap;

  assign load    = reg_wr && (reg_addr == A_COUNT);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign clr_cap = wr_stat && reg_wdata[0];
  assign clr_ref = wr_stat && reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      ref_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CTRL:  ctrl_q <= tmr_ctrl_t'(reg_wdata[CTRL_W-1:0]);
        A_PRE:   pre_q  <= reg_wdata[PRE_W-1:0];
        A_REF:   ref_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  tmr_pin_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(tmr_in), .edge_sel_i(ctrl_q.edge_sel),
    .rise_o(pin_rise), .sel_o(pin_sel)
  );

  assign src_pulse = ctrl_q.run && (ctrl_q.mode != MODE_EVENT) &&
                     (ctrl_q.ext_src ? pin_rise : 1'b1);

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(load), .src_i(src_pulse),
    .div_i(pre_q), .tick_o(tick)
  );

  assign inc    = ctrl_q.run && ((ctrl_q.mode == MODE_EVENT) ? pin_sel : tick);
  assign cap_ev = ctrl_q.run && (ctrl_q.mode == MODE_CAPTURE) && pin_sel;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .inc_i(inc), .load_i(load), .load_val_i(reg_wdata),
    .ref_i(ref_q), .restart_i(ctrl_q.restart), .toggle_i(ctrl_q.toggle),
    .cap_i(cap_ev), .cnt_o(cnt), .cap_o(cap), .match_o(match), .tout_o(tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_cap_q <= 1'b0;
      st_ref_q <= 1'b0;
    end else begin
      st_cap_q <= (st_cap_q && !clr_cap) || cap_ev;
      st_ref_q <= (st_ref_q && !clr_ref) || match;
    end
  end

  assign irq = (st_ref_q && ctrl_q.ref_ie) || (st_cap_q && ctrl_q.cap_ie);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      A_PRE:   reg_rdata = {{(CNT_W-PRE_W){1'b0}}, pre_q};
      A_REF:   reg_rdata = ref_q;
      A_CAP:   reg_rdata = cap;
      A_COUNT: reg_rdata = cnt;
      A_STAT:  reg_rdata = {{(CNT_W-2){1'b0}}, st_ref_q, st_cap_q};
      default: reg_rdata = '0;
    endcase
  end

  AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ref_q && !clr_ref) |=> st_ref_q); // R13
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_cap_q && !clr_cap) |=> st_cap_q); // R13
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_ref_q || st_cap_q)); // R6
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> st_ref_q); // R6
endmodule

// File: tb/mmtimer_tb_top.sv
`timescale 1ns/1ps
module mmtimer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        tmr_in = 1'b0;
  logic        tmr_out, irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mmtimer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_in(tmr_in),
    .tmr_out(tmr_out), .irq(irq)
  );

  function automatic logic [15:0] mk(bit run, bit [1:0] mode, bit ext, bit [1:0] edg,
                                     bit rst_m, bit tog, bit rie, bit cie);
    return {6'd0, cie, rie, tog, rst_m, edg, ext, mode, run};
  endfunction
  function automatic int exp_pre(int k, int p);  return k / (p + 1); endfunction
  function automatic int exp_rst(int k, int r);  return k % (r + 1); endfunction

  task automatic chk(int got, int exp, string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic start(logic [15:0] c, logic [15:0] pre, logic [15:0] rv, logic [15:0] cv);
    wr(3'd0, c & 16'hFFFE);
    wr(3'd1, pre);
    wr(3'd2, rv);
    wr(3'd4, cv);
    wr(3'd5, 16'h0003);
    wr(3'd0, c | 16'h0001);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      tmr_in = 1'b1; repeat (4) @(negedge clk);
      tmr_in = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_k(int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, t0v;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd4, v); chk(v, 0, "R1 count");
    rd(3'd5, v); chk(v, 0, "R1 status");
    rd(3'd3, v); chk(v, 0, "R1 capture");
    chk(int'(tmr_out), 1, "R1 tmr_out");
    chk(int'(irq), 0, "R1 irq");

    // R2 prescaler, random
    for (int t = 0; t < 16; t++) begin
      int p = int'($urandom_range(7, 0));
      int k = int'($urandom_range(40, 0));
      start(mk(1, 2'b00, 0, 2'b00, 0, 0, 0, 0), 16'(p), 16'hFFFF, 16'h0000);
      wait_k(k);
      rd(3'd4, v); chk(v, exp_pre(k, p), "R2 prescaled count");
    end

    // R5 restart period, random; R6 flag
    for (int t = 0; t < 16; t++) begin
      int r = int'($urandom_range(15, 1));
      int k = int'($urandom_range(50, 0));
      start(mk(1, 2'b00, 0, 2'b00, 1, 0, 0, 0), 16'd0, 16'(r), 16'h0000);
      wait_k(k);
      rd(3'd4, v); chk(v, exp_rst(k, r), "R5 restart count");
      rd(3'd5, v); chk((v >> 1) & 1, (k >= r) ? 1 : 0, "R6 ref flag");
    end

    // R6, R7 pulse mode and interrupt, reference 3
    start(mk(1, 2'b00, 0, 2'b00, 1, 0, 1, 0), 16'd0, 16'd3, 16'h0000);
    wait_k(2);
    chk(int'(tmr_out), 1, "R7 idle high");
    chk(int'(irq), 0, "R6 irq before match");
    wait_k(1);
    chk(int'(tmr_out), 0, "R7 pulse low");
    chk(int'(irq), 1, "R6 irq on match");
    rd(3'd5, v); chk(v, 2, "R6 status after match");
    wait_k(1);
    chk(int'(tmr_out), 1, "R7 pulse one clock");
    rd(3'd4, v); chk(v, 0, "R5 restart to zero");

    // R8 toggle mode, reference 2
    start(mk(1, 2'b00, 0, 2'b00, 1, 1, 0, 0), 16'd0, 16'd2, 16'h0000);
    t0v = int'(tmr_out);
    wait_k(2); chk(int'(tmr_out), 1 - t0v, "R8 first toggle");
    wait_k(2); chk(int'(tmr_out), 1 - t0v, "R8 hold between");
    wait_k(1); chk(int'(tmr_out), t0v, "R8 second toggle");

    // R4 wrap
    start(mk(1, 2'b00, 0, 2'b00, 0, 0, 0, 0), 16'd0, 16'h1234, 16'hFFFE);
    wait_k(1); rd(3'd4, v); chk(v, 16'hFFFF, "R4 top");
    wait_k(1); rd(3'd4, v); chk(v, 0, "R4 wrap");

    // R3 freeze
    wr(3'd0, mk(0, 2'b00, 0, 2'b00, 0, 0, 0, 0));
    rd(3'd4, t0v);
    wait_k(20);
    rd(3'd4, v); chk(v, t0v, "R3 frozen count");

    // R13 set wins over clear: reference 0 with restart matches every edge
    start(mk(1, 2'b00, 0, 2'b00, 1, 0, 0, 0), 16'd0, 16'd0, 16'h0000);
    wr(3'd5, 16'h0002);
    rd(3'd5, v); chk((v >> 1) & 1, 1, "R13 set wins");
    wr(3'd0, mk(0, 2'b00, 0, 2'b00, 1, 0, 0, 0));
    wr(3'd5, 16'h0002);
    rd(3'd5, v); chk(v, 0, "R13 clear");

    // R9 capture on rising edge, slow counter
    start(mk(1, 2'b01, 0, 2'b01, 0, 0, 0, 1), 16'd255, 16'hFFFF, 16'd5);
    pulses(1);
    rd(3'd3, v); chk(v, 5, "R9 captured value");
    rd(3'd5, v); chk(v, 1, "R9 capture flag");
    chk(int'(irq), 1, "R9 capture irq");

    // R10 falling-edge select ignores rising edge
    start(mk(1, 2'b01, 0, 2'b10, 0, 0, 0, 0), 16'd255, 16'hFFFF, 16'd9);
    tmr_in = 1'b1; wait_k(8);
    rd(3'd3, v); chk(v, 5, "R10 rise ignored capture");
    rd(3'd5, v); chk(v, 0, "R10 rise ignored flag");
    tmr_in = 1'b0; wait_k(8);
    rd(3'd3, v); chk(v, 9, "R10 falling capture");

    // R11 event mode
    start(mk(1, 2'b10, 0, 2'b11, 0, 0, 0, 0), 16'd0, 16'hFFFF, 16'd0);
    pulses(3);
    rd(3'd4, v); chk(v, 6, "R11 both edges");
    start(mk(1, 2'b10, 0, 2'b01, 0, 0, 0, 0), 16'd5, 16'hFFFF, 16'd0);
    pulses(4);
    rd(3'd4, v); chk(v, 4, "R11 rising, prescaler bypassed");
    start(mk(1, 2'b10, 0, 2'b00, 0, 0, 0, 0), 16'd0, 16'hFFFF, 16'd0);
    pulses(3);
    rd(3'd4, v); chk(v, 0, "R10 no edge selected");

    // R12 pin as prescaler source
    start(mk(1, 2'b00, 1, 2'b00, 0, 0, 0, 0), 16'd1, 16'hFFFF, 16'd0);
    pulses(6);
    rd(3'd4, v); chk(v, 3, "R12 external source");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule